// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a 24-bit down-counter that wraps at zero and sits behind four word-wide registers on a single-cycle register bus. Software programs a reload value, clears the live count, and enables counting. Every (reload + 1) ticks the count steps from one to zero. That step sets a sticky status flag and, when enabled, raises an interrupt request.

The count advances either on every cycle of the system clock or on each rising edge of a slow reference clock. The reference clock is first brought into the system clock domain by a short synchronizer. A build parameter declares whether a reference clock exists at all. When it does not, the source-select bit is locked to the system clock. A read-only calibration word reports three things: whether a reference clock is present, whether the ten-millisecond reload figure is exact, and that figure itself.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0x0000_0004, the reload and current-value words read 0, and `irq_pending_o` is low.
- R2: While enabled (control bit 0 = 1), each tick moves a nonzero count down by one and loads the reload value into a zero count. The count therefore returns to any value every (reload + 1) ticks. A read of the current-value word (offset 0x8) returns the live count.
- R3: Any write to the current-value word sets the count to zero whatever the data. The count reloads on the next tick. Such a write never raises `irq_pending_o`.
- R4: The reached-zero flag (control bit 16) is set when a tick moves the count from 1 to 0. It is cleared by a read of the control word and by a write to the current-value word. A read returns the flag as it was before the clear, and a set in the same cycle as a clear wins.
- R5: `irq_pending_o` rises on a 1-to-0 tick only when control bit 1 is 1. It then stays high until `irq_ack_i` is asserted.
- R6: With a reload value of zero, the count stays at zero after it next reaches zero.
- R7: Control bit 2 selects the tick: 1 ticks on every system clock, and 0 ticks once per rising edge of `ref_clk_i` after two synchronizing flops.
- R8: With `HAS_REF` = 0, control bit 2 reads 1 and ignores writes. Calibration bit 31 then reads 1; otherwise it reads 0.
- R9: The calibration word (offset 0xC) holds the `CAL_SKEW` flag at bit 30 and the ten-millisecond reload at bits 23:0. Reload (offset 0x4) and current-value bits 31:24 read zero, and so do unused control bits.
- R10: While control bit 0 is 0 the count holds its value.
- R11: Read data is registered. It appears on `bus_rdata_o` in the cycle after the access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Asynchronous reference clock |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_pending_o | output | 1 | Sticky interrupt request |
| irq_ack_i | input | 1 | Clears the interrupt request |

## Verification
A wrong next-state choice in the counter shows up in the current-value word one tick later, either as a skipped reload or as a value off by one. It also shifts the cycle in which the reached-zero flag and the interrupt request rise away from the (reload + 1) grid. A flag with a wrong clear priority is seen on the first control read after a zero crossing. A source-select error is seen as counting without reference edges, or as no counting with them, within a few cycles of the edges.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BUS_W = 32;

  // word index = byte address [ADDR_W-1:2]
  typedef enum logic [1:0] {
    WSEL_CTRL   = 2'd0,
    WSEL_RELOAD = 2'd1,
    WSEL_CUR    = 2'd2,
    WSEL_CAL    = 2'd3
  } word_sel_e;

  localparam int CB_RUN  = 0;
  localparam int CB_IE   = 1;
  localparam int CB_SRC  = 2;
  localparam int CB_ZERO = 16;
  localparam int CAL_NOREF_BIT = 31;
  localparam int CAL_SKEW_BIT  = 30;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchronizing flops plus one history flop for edge detection
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[STAGES-1:0], async_i};
  end

  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == '0)      cnt_q <= reload_i;
      else                  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign zero_hit_o = tick_i && !clr_i && (cnt_q == CNT_W'(1));

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0)); // R3
  AST_WRAP_LOADS: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i && cnt_o == '0) |=> (cnt_o == $past(reload_i))); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i && cnt_o != '0) |=> (cnt_o == CNT_W'($past(cnt_o) - 1'b1))); // R2
  AST_PARK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_o == '0 && reload_i == '0) |=> (cnt_o == '0)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_o)); // R10
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int               CNT_W       = 24,
  parameter bit               HAS_REF     = 1'b1,
  parameter bit               CAL_SKEW    = 1'b1,
  parameter logic [CNT_W-1:0] CAL_TENMS   = 24'd2499999,
  parameter int               SYNC_STAGES = 2,
  parameter int               ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_pending_o,
  input  logic              irq_ack_i
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int PAD_W  = BUS_W - CNT_W;

  logic [WORD_W-1:0] word;
  logic hit_ctrl, hit_reload, hit_cur, hit_cal;
  logic wr_ctrl, wr_reload, wr_cur, rd_ctrl, rd_any;

  assign word       = bus_addr_i[ADDR_W-1:2];
  assign hit_ctrl   = (word == WORD_W'(WSEL_CTRL));
  assign hit_reload = (word == WORD_W'(WSEL_RELOAD));
  assign hit_cur    = (word == WORD_W'(WSEL_CUR));
  assign hit_cal    = (word == WORD_W'(WSEL_CAL));
  assign wr_ctrl    = bus_sel_i &  bus_wr_i & hit_ctrl;
  assign wr_reload  = bus_sel_i &  bus_wr_i & hit_reload;
  assign wr_cur     = bus_sel_i &  bus_wr_i & hit_cur;
  assign rd_any     = bus_sel_i & ~bus_wr_i;
  assign rd_ctrl    = rd_any & hit_ctrl;

  logic unused_bus_bits;
  assign unused_bus_bits = ^{bus_wdata_i[BUS_W-1:CNT_W], bus_addr_i[1:0], hit_cal};

  // control and reload state
  logic             run_q, ie_q, src_q;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
      src_q <= 1'b1;
    end else if (wr_ctrl) begin
      run_q <= bus_wdata_i[CB_RUN];
      ie_q  <= bus_wdata_i[CB_IE];
      src_q <= HAS_REF ? bus_wdata_i[CB_SRC] : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            reload_q <= '0;
    else if (wr_reload) reload_q <= bus_wdata_i[CNT_W-1:0];
  end

  // tick generation
  logic ref_rise, tick;

  tick_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ref_clk_i),
    .rise_o  (ref_rise)
  );

  assign tick = run_q & (src_q | ref_rise);

  // counter
  logic [CNT_W-1:0] cnt;
  logic             zero_hit;

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .clr_i      (wr_cur),
    .reload_i   (reload_q),
    .cnt_o      (cnt),
    .zero_hit_o (zero_hit)
  );

  // sticky flag and interrupt request
  logic zero_flag_q;

  always_ff @(posedge clk) begin
    if (rst)                    zero_flag_q <= 1'b0;
    else if (zero_hit)          zero_flag_q <= 1'b1;
    else if (rd_ctrl || wr_cur) zero_flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                    irq_pending_o <= 1'b0;
    else if (zero_hit && ie_q)  irq_pending_o <= 1'b1;
    else if (irq_ack_i)         irq_pending_o <= 1'b0;
  end

  // read mux and registered read port
  logic [BUS_W-1:0] ctrl_word, cal_word, rd_word;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CB_RUN]   = run_q;
    ctrl_word[CB_IE]    = ie_q;
    ctrl_word[CB_SRC]   = src_q;
    ctrl_word[CB_ZERO]  = zero_flag_q;
    cal_word                = {{PAD_W{1'b0}}, CAL_TENMS};
    cal_word[CAL_NOREF_BIT] = ~HAS_REF;
    cal_word[CAL_SKEW_BIT]  = CAL_SKEW;
  end

  always_comb begin
    case (word_sel_e'(word[1:0]))
      WSEL_CTRL:   rd_word = ctrl_word;
      WSEL_RELOAD: rd_word = {{PAD_W{1'b0}}, reload_q};
      WSEL_CUR:    rd_word = {{PAD_W{1'b0}}, cnt};
      default:     rd_word = cal_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata_o <= '0;
    else if (rd_any) bus_rdata_o <= rd_word;
  end

  AST_CUR_WR_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_cur && !irq_pending_o) |=> !irq_pending_o); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_pending_o && !irq_ack_i) |=> irq_pending_o); // R5
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    (!irq_pending_o && !ie_q) |=> !irq_pending_o); // R5
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !zero_hit) |=> !zero_flag_q); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(bus_rdata_o)); // R11
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_clk = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nr;
  logic        irq, irq_nr;
  int checks = 0;
  int errors = 0;
  logic [31:0] rd, rd_nr;

  always #2 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_pending_o(irq), .irq_ack_i(ack));

  tick_timer #(.HAS_REF(1'b0)) dut_nr (
    .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_nr),
    .irq_pending_o(irq_nr), .irq_ack_i(ack));

  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

  typedef struct packed { logic [23:0] reload; logic [15:0] waitn; } vec_t;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{24'd5, 16'd0}, '{24'd5, 16'd1}, '{24'd5, 16'd3}, '{24'd5, 16'd6},
    '{24'd5, 16'd7}, '{24'd0, 16'd4}, '{24'd1, 16'd5}, '{24'd100, 16'd50},
    '{24'hFFFFFF, 16'd3}};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    rd = rdata; rd_nr = rdata_nr;
  endtask

  task automatic quiesce();
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  function automatic logic [31:0] exp_cur(input longint r, input longint w);
    if (w == 0) return 32'h0;
    return 32'(r - ((w - 1) % (r + 1)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_read(A_CTRL);  chk("R1 ctrl", rd, 32'h4); chk("R1 ctrl noref", rd_nr, 32'h4);
    bus_read(A_RLD);   chk("R1 reload", rd, 32'h0);
    bus_read(A_CUR);   chk("R1 cur", rd, 32'h0);
    // R9 / R8 calibration
    bus_read(A_CAL);   chk("R9 cal", rd, 32'h4026259F); chk("R8 cal noref", rd_nr, 32'hC026259F);
    // R11 read data holds
    repeat (3) @(negedge clk); chk("R11 hold", rdata, 32'h4026259F);

    // R9 upper bits of reload read zero
    bus_write(A_RLD, 32'hFFFF_FFFF);
    bus_read(A_RLD);   chk("R9 reload pad", rd, 32'h00FF_FFFF);

    // R8 source lock vs writable source
    bus_write(A_CTRL, 32'h0000_0001);
    bus_read(A_CTRL);  chk("R7 src writable", rd, 32'h1); chk("R8 src locked", rd_nr, 32'h5);
    quiesce();

    // R2 / R6 table of reload values and wait times
    for (int i = 0; i < NV; i++) begin
      bus_write(A_CTRL, 32'h0);
      bus_write(A_RLD, {8'h0, VECS[i].reload});
      bus_write(A_CUR, 32'h0);
      bus_write(A_CTRL, 32'h5);
      repeat (int'(VECS[i].waitn)) @(negedge clk);
      bus_read(A_CUR);
      chk(VECS[i].reload == 0 ? "R6 park" : "R2 count", rd,
          exp_cur(longint'(VECS[i].reload), longint'(VECS[i].waitn)));
    end

    // R10 disabled counter holds
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CUR);
    rd_nr = rd;
    repeat (10) @(negedge clk);
    bus_read(A_CUR);   chk("R10 hold", rd, rd_nr);
    quiesce();

    // R5 interrupt with enable, sticky until ack; R4 flag clear on read
    bus_write(A_RLD, 32'd3);
    bus_write(A_CUR, 32'h0);
    bus_write(A_CTRL, 32'h7);
    repeat (3) @(negedge clk); chk("R5 not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);            chk("R5 rise", {31'b0, irq}, 32'h1);
    bus_read(A_CTRL);  chk("R4 flag set", rd, 32'h0001_0007);
    bus_read(A_CTRL);  chk("R4 flag cleared by read", rd, 32'h7);
    bus_write(A_CTRL, 32'h0);
    chk("R5 sticky", {31'b0, irq}, 32'h1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R5 ack", {31'b0, irq}, 32'h0);
    quiesce();

    // R5 no interrupt without enable, flag still set
    bus_write(A_RLD, 32'd3);
    bus_write(A_CUR, 32'h0);
    bus_write(A_CTRL, 32'h5);
    repeat (4) @(negedge clk);
    chk("R5 masked", {31'b0, irq}, 32'h0);
    bus_read(A_CTRL);  chk("R4 flag without ie", rd, 32'h0001_0005);
    quiesce();

    // R3 write to current zeroes count, clears flag, no interrupt
    bus_write(A_RLD, 32'd20);
    bus_write(A_CUR, 32'h0);
    bus_write(A_CTRL, 32'h5);
    repeat (21) @(negedge clk);
    bus_write(A_CTRL, 32'h7);
    bus_write(A_CUR, 32'h0012_3456);
    bus_read(A_CUR);   chk("R3 cur zeroed", rd, 32'h0);
    bus_read(A_CTRL);  chk("R3 flag cleared by write", rd, 32'h7);
    chk("R3 no irq", {31'b0, irq}, 32'h0);
    bus_read(A_CUR);   chk("R3 reload next tick", rd, 32'd19);
    quiesce();

    // R7 reference clock edges drive the count
    bus_write(A_RLD, 32'd100);
    bus_write(A_CUR, 32'h0);
    bus_write(A_CTRL, 32'h1);
    repeat (6) @(negedge clk);
    bus_read(A_CUR);   chk("R7 no edges no count", rd, 32'h0);
    for (int p = 0; p < 5; p++) begin
      ref_clk = 1'b1; repeat (3) @(negedge clk);
      ref_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    bus_read(A_CUR);   chk("R7 ref count", rd, 32'd96);
    quiesce();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule